// File: doc/BRIEF.md
# Nibble Datapath Executor

This block carries out the data-handling share of a 16-bit instruction stream for a small 4-bit controller. It keeps a file of sixteen 4-bit working registers, a banked data memory of 4-bit words and a single carry flag. On each cycle where an instruction is presented as valid, it decodes the word and commits the result on the next rising clock edge. The operations are:

- logical operations between a register and a memory word, with the result written to the register;
- logical operations between a memory word and an immediate, with the result written to memory;
- loads, stores and immediate writes to memory;
- a copy within one memory row whose target column comes from a register;
- a one-bit right rotate of a register through the carry.

Two mask-test instructions check selected bits of a memory word. When the test succeeds they raise a one-cycle skip request to the sequencer. Program flow, peripherals and timers belong to other blocks. The current bank number comes in from outside and forms the top of every data-memory address. Two debug read ports show any memory word and any register without side effects.

Top module: `nibble_exec`

## Requirements
- R1: A synchronous active-low reset clears every register, every memory word, the carry and the skip request to zero.
- R2: The instruction word is split into fields as follows. The opcode is bits [15:10], the row field is [9:8], the column field is [7:4], and the operand field (register index, immediate or mask) is [3:0]. The memory word addressed is at {bank, row, column}.
- R3: Opcode 001000 writes reg[f] AND M into reg[f]. Opcode 001010 writes reg[f] OR M into reg[f]. Opcode 001100 writes reg[f] XOR M into reg[f]. None of these three changes memory.
- R4: Opcode 001001 writes M AND f into M. Opcode 001011 writes M OR f into M.
- R5: Opcode 110100 loads M into reg[f]. Opcode 110101 stores reg[f] into M. Opcode 111001 writes the immediate f into M.
- R6: Opcode 110110 copies M into the word at {bank, row, reg[f]}. The source word is left unchanged.
- R7: Opcode 111100 succeeds when (M AND f) equals f. Opcode 111101 succeeds when (M AND f) equals 0, so a zero mask always succeeds. A success drives skip_req high for exactly the cycle after the instruction's clock edge.
- R8: The word 0x00E0 | f rotates reg[f] right through the carry. The new reg[f] is {carry, reg[f][3:1]}, and the new carry is the old reg[f][0].
- R9: Every instruction other than the rotate leaves the carry unchanged.
- R10: An undefined opcode, or any word presented with instr_valid low, changes no register, no memory word and no carry, and raises no skip.
- R11: Different bank values reach separate memory pages that share the same row and column fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Execute instr on this clock edge |
| instr | input | 16 | Instruction word |
| bank | input | 2 | Data memory bank, top of the address |
| dbg_mem_addr | input | 8 | Memory word shown on dbg_mem_data |
| dbg_reg_sel | input | 4 | Register shown on dbg_reg_data |
| skip_req | output | 1 | Mask test succeeded on the previous edge |
| carry | output | 1 | Carry flag |
| dbg_mem_data | output | 4 | Content of memory at dbg_mem_addr |
| dbg_reg_data | output | 4 | Content of register dbg_reg_sel |

## Verification
The hardest state to reach from the ports is the indirect copy. Its target column exists only as the content of a register, so two earlier instructions have to set it up: a memory word is written and then loaded into that register. Only after that can the copy be issued, and both the target and the untouched source are read back. The rotate chain is sequenced so that a 1 leaves bit 0 and then comes back in at bit 3. Logic operations are then issued with the carry at 1, so that an unintended carry clear shows up.

// File: rtl/nx_pkg.sv
// Package nx_pkg
// Shared opcode constants and the decoded-operation type for the nibble
// executor. Assumes the 6-bit major opcode sits at the top of the word.
package nx_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_AND_RM = 6'b001000;
    localparam logic [OPC_W-1:0] OPC_AND_MI = 6'b001001;
    localparam logic [OPC_W-1:0] OPC_OR_RM  = 6'b001010;
    localparam logic [OPC_W-1:0] OPC_OR_MI  = 6'b001011;
    localparam logic [OPC_W-1:0] OPC_XOR_RM = 6'b001100;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 6'b110100;
    localparam logic [OPC_W-1:0] OPC_STORE  = 6'b110101;
    localparam logic [OPC_W-1:0] OPC_MOVIND = 6'b110110;
    localparam logic [OPC_W-1:0] OPC_MOVIMM = 6'b111001;
    localparam logic [OPC_W-1:0] OPC_TSTONE = 6'b111100;
    localparam logic [OPC_W-1:0] OPC_TSTZER = 6'b111101;

    // Value of every bit above the operand field for the rotate word
    localparam int ROT_CODE = 14;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_AND_RM,
        OP_AND_MI,
        OP_OR_RM,
        OP_OR_MI,
        OP_XOR_RM,
        OP_LOAD,
        OP_STORE,
        OP_MOVIND,
        OP_MOVIMM,
        OP_TSTONE,
        OP_TSTZER,
        OP_ROTR
    } nx_op_e;

endpackage

// File: rtl/nx_decode.sv
// Module nx_decode
// Splits an instruction word into operation, row, column and operand
// fields. Purely combinational. Assumes the layout
// {opcode, row, column, operand} from most to least significant bit.
// Undefined opcodes decode to OP_NOP.
module nx_decode
    import nx_pkg::*;
#(
    parameter int DH_W  = 2,
    parameter int DL_W  = 4,
    parameter int NIB_W = 4,
    localparam int INSTR_W = OPC_W + DH_W + DL_W + NIB_W
) (
    input  logic [INSTR_W-1:0] instr,
    output nx_op_e             op,
    output logic [DH_W-1:0]    row,
    output logic [DL_W-1:0]    col,
    output logic [NIB_W-1:0]   fld
);

    localparam int HI_W = INSTR_W - NIB_W;

    logic [OPC_W-1:0] opc;
    logic [HI_W-1:0]  upper;

    assign opc   = instr[INSTR_W-1 -: OPC_W];
    assign upper = instr[INSTR_W-1 -: HI_W];
    assign row   = instr[NIB_W+DL_W +: DH_W];
    assign col   = instr[NIB_W +: DL_W];
    assign fld   = instr[NIB_W-1:0];

    // Map the opcode (or the full rotate prefix) onto an operation
    always_comb begin
        op = OP_NOP;
        if (upper == HI_W'(ROT_CODE)) begin
            op = OP_ROTR;
        end else begin
            case (opc)
                OPC_AND_RM: op = OP_AND_RM;
                OPC_AND_MI: op = OP_AND_MI;
                OPC_OR_RM:  op = OP_OR_RM;
                OPC_OR_MI:  op = OP_OR_MI;
                OPC_XOR_RM: op = OP_XOR_RM;
                OPC_LOAD:   op = OP_LOAD;
                OPC_STORE:  op = OP_STORE;
                OPC_MOVIND: op = OP_MOVIND;
                OPC_MOVIMM: op = OP_MOVIMM;
                OPC_TSTONE: op = OP_TSTONE;
                OPC_TSTZER: op = OP_TSTZER;
                default:    op = OP_NOP;
            endcase
        end
    end

endmodule

// File: rtl/nx_store.sv
// Module nx_store
// Array of DATA_W-bit words with one synchronous write port and two
// combinational read ports (operand and debug). Synchronous active-low
// reset clears every word. Used for both the register file and the
// banked data memory.
module nx_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_d,
    output logic [DATA_W-1:0] rdata_d
);

    logic [DATA_W-1:0] words [DEPTH];

    // Clear on reset, otherwise commit a single word write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata_a = words[raddr_a];
    assign rdata_d = words[raddr_d];

    AST_WADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$isunknown(waddr)); // R2

endmodule

// File: rtl/nx_alu.sv
// Module nx_alu
// Combinational result unit. From the decoded operation and the register,
// memory, immediate and carry operands, it produces the write enables and
// data for both stores, the carry update and the mask-test outcome.
// Assumes that at most one store is written per operation.
module nx_alu
    import nx_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  nx_op_e           op,
    input  logic [NIB_W-1:0] reg_val,
    input  logic [NIB_W-1:0] mem_val,
    input  logic [NIB_W-1:0] fld,
    input  logic             carry_in,
    output logic             reg_we,
    output logic [NIB_W-1:0] reg_wdata,
    output logic             mem_we,
    output logic [NIB_W-1:0] mem_wdata,
    output logic             mem_indirect,
    output logic             carry_we,
    output logic             carry_out,
    output logic             test_hit
);

    logic [NIB_W-1:0] masked;

    assign masked = mem_val & fld;

    // Select the result and destination for the current operation
    always_comb begin
        reg_we       = 1'b0;
        reg_wdata    = reg_val;
        mem_we       = 1'b0;
        mem_wdata    = mem_val;
        mem_indirect = 1'b0;
        carry_we     = 1'b0;
        carry_out    = carry_in;
        test_hit     = 1'b0;
        case (op)
            OP_AND_RM: begin
                reg_we    = 1'b1;
                reg_wdata = reg_val & mem_val;
            end
            OP_OR_RM: begin
                reg_we    = 1'b1;
                reg_wdata = reg_val | mem_val;
            end
            OP_XOR_RM: begin
                reg_we    = 1'b1;
                reg_wdata = reg_val ^ mem_val;
            end
            OP_AND_MI: begin
                mem_we    = 1'b1;
                mem_wdata = mem_val & fld;
            end
            OP_OR_MI: begin
                mem_we    = 1'b1;
                mem_wdata = mem_val | fld;
            end
            OP_LOAD: begin
                reg_we    = 1'b1;
                reg_wdata = mem_val;
            end
            OP_STORE: begin
                mem_we    = 1'b1;
                mem_wdata = reg_val;
            end
            OP_MOVIMM: begin
                mem_we    = 1'b1;
                mem_wdata = fld;
            end
            OP_MOVIND: begin
                mem_we       = 1'b1;
                mem_wdata    = mem_val;
                mem_indirect = 1'b1;
            end
            OP_TSTONE: test_hit = (masked == fld);
            OP_TSTZER: test_hit = (masked == '0);
            OP_ROTR: begin
                reg_we    = 1'b1;
                reg_wdata = {carry_in, reg_val[NIB_W-1:1]};
                carry_we  = 1'b1;
                carry_out = reg_val[0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nibble_exec.sv
// Module nibble_exec
// Top of the nibble datapath. It decodes one instruction per valid cycle
// and commits register, memory and carry updates on the next rising
// edge. skip_req is registered and is high for one cycle after a
// successful mask test. The memory address is {bank, row, column}. The
// indirect copy takes its column from a register, so the register width
// must equal the column width.
module nibble_exec
    import nx_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int DH_W   = 2,
    parameter int DL_W   = 4,
    parameter int NIB_W  = 4,
    localparam int INSTR_W = OPC_W + DH_W + DL_W + NIB_W,
    localparam int MEM_AW  = BANK_W + DH_W + DL_W,
    localparam int REG_AW  = NIB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [BANK_W-1:0]  bank,
    input  logic [MEM_AW-1:0]  dbg_mem_addr,
    input  logic [REG_AW-1:0]  dbg_reg_sel,
    output logic               skip_req,
    output logic               carry,
    output logic [NIB_W-1:0]   dbg_mem_data,
    output logic [NIB_W-1:0]   dbg_reg_data
);

    nx_op_e           op;
    logic [DH_W-1:0]  row;
    logic [DL_W-1:0]  col;
    logic [NIB_W-1:0] fld;

    logic [NIB_W-1:0] reg_val, mem_val;
    logic             alu_reg_we, alu_mem_we, alu_carry_we, mem_indirect;
    logic [NIB_W-1:0] reg_wdata, mem_wdata;
    logic             carry_nxt, test_hit;

    logic              reg_we, mem_we;
    logic [MEM_AW-1:0] mem_raddr, mem_waddr;

    nx_decode #(.DH_W(DH_W), .DL_W(DL_W), .NIB_W(NIB_W)) u_dec (
        .instr (instr),
        .op    (op),
        .row   (row),
        .col   (col),
        .fld   (fld)
    );

    assign mem_raddr = {bank, row, col};
    assign mem_waddr = mem_indirect ? {bank, row, DL_W'(reg_val)} : mem_raddr;
    assign reg_we    = instr_valid & alu_reg_we;
    assign mem_we    = instr_valid & alu_mem_we;

    nx_store #(.ADDR_W(REG_AW), .DATA_W(NIB_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .waddr   (fld),
        .wdata   (reg_wdata),
        .raddr_a (fld),
        .rdata_a (reg_val),
        .raddr_d (dbg_reg_sel),
        .rdata_d (dbg_reg_data)
    );

    nx_store #(.ADDR_W(MEM_AW), .DATA_W(NIB_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (mem_raddr),
        .rdata_a (mem_val),
        .raddr_d (dbg_mem_addr),
        .rdata_d (dbg_mem_data)
    );

    nx_alu #(.NIB_W(NIB_W)) u_alu (
        .op           (op),
        .reg_val      (reg_val),
        .mem_val      (mem_val),
        .fld          (fld),
        .carry_in     (carry),
        .reg_we       (alu_reg_we),
        .reg_wdata    (reg_wdata),
        .mem_we       (alu_mem_we),
        .mem_wdata    (mem_wdata),
        .mem_indirect (mem_indirect),
        .carry_we     (alu_carry_we),
        .carry_out    (carry_nxt),
        .test_hit     (test_hit)
    );

    // Carry flag: updated only by the rotate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry <= 1'b0;
        end else if (instr_valid && alu_carry_we) begin
            carry <= carry_nxt;
        end
    end

    // Skip request: one cycle after a successful mask test
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_req <= 1'b0;
        end else begin
            skip_req <= instr_valid && test_hit;
        end
    end

    AST_SKIP_FROM_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> $past(instr_valid && (op == OP_TSTONE || op == OP_TSTZER))); // R7

    AST_CARRY_ONLY_ROT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(carry) |-> $past(instr_valid && op == OP_ROTR)); // R9

    AST_ROT_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op == OP_ROTR) |=> (carry == $past(reg_val[0]))); // R8

    AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && mem_we)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid || op == OP_NOP) |-> !(reg_we || mem_we)); // R10

endmodule

// File: tb/nibble_exec_test.sv
// Self-checking bench for nibble_exec: a table of vectors walked by one
// loop, then directed reset checks.
module nibble_exec_test;

    localparam int KREG = 0;
    localparam int KMEM = 1;
    localparam int KSKP = 2;
    localparam int KCRY = 3;
    localparam int NV   = 33;

    // {valid, instr, bank, kind, addr/sel, expected, requirement}
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 16'hE43A, 2'd0, 2'd1, 8'h03, 4'hA, 4'd5},  // R5 imm move
        {1'b1, 16'hD032, 2'd0, 2'd0, 8'h02, 4'hA, 4'd5},  // R5 load
        {1'b1, 16'hE456, 2'd0, 2'd1, 8'h05, 4'h6, 4'd5},  // R5
        {1'b1, 16'h2052, 2'd0, 2'd0, 8'h02, 4'h2, 4'd3},  // R3 AND
        {1'b1, 16'h2832, 2'd0, 2'd0, 8'h02, 4'hA, 4'd3},  // R3 OR
        {1'b1, 16'h3052, 2'd0, 2'd0, 8'h02, 4'hC, 4'd3},  // R3 XOR
        {1'b0, 16'h0000, 2'd0, 2'd1, 8'h05, 4'h6, 4'd3},  // R3 memory intact
        {1'b1, 16'h2433, 2'd0, 2'd1, 8'h03, 4'h2, 4'd4},  // R4 AND imm
        {1'b1, 16'h2C35, 2'd0, 2'd1, 8'h03, 4'h7, 4'd4},  // R4 OR imm
        {1'b1, 16'hD502, 2'd0, 2'd1, 8'h10, 4'hC, 4'd2},  // R2 row field
        {1'b1, 16'hE479, 2'd0, 2'd1, 8'h07, 4'h9, 4'd5},  // R5
        {1'b1, 16'hD074, 2'd0, 2'd0, 8'h04, 4'h9, 4'd5},  // R5
        {1'b1, 16'hD904, 2'd0, 2'd1, 8'h19, 4'hC, 4'd6},  // R6 indirect
        {1'b0, 16'h0000, 2'd0, 2'd1, 8'h10, 4'hC, 4'd6},  // R6 source kept
        {1'b1, 16'hF036, 2'd0, 2'd2, 8'h00, 4'h1, 4'd7},  // R7 ones hit
        {1'b1, 16'hF038, 2'd0, 2'd2, 8'h00, 4'h0, 4'd7},  // R7 ones miss
        {1'b1, 16'hF438, 2'd0, 2'd2, 8'h00, 4'h1, 4'd7},  // R7 zeros hit
        {1'b1, 16'hF431, 2'd0, 2'd2, 8'h00, 4'h0, 4'd7},  // R7 zeros miss
        {1'b1, 16'hF030, 2'd0, 2'd2, 8'h00, 4'h1, 4'd7},  // R7 empty mask
        {1'b1, 16'hF430, 2'd0, 2'd2, 8'h00, 4'h1, 4'd7},  // R7 empty mask
        {1'b0, 16'h0000, 2'd0, 2'd2, 8'h00, 4'h0, 4'd7},  // R7 one cycle
        {1'b1, 16'h00E2, 2'd0, 2'd0, 8'h02, 4'h6, 4'd8},  // R8
        {1'b1, 16'h00E2, 2'd0, 2'd0, 8'h02, 4'h3, 4'd8},  // R8
        {1'b1, 16'h00E2, 2'd0, 2'd3, 8'h00, 4'h1, 4'd8},  // R8 carry out
        {1'b1, 16'h00E2, 2'd0, 2'd0, 8'h02, 4'h8, 4'd8},  // R8 carry in
        {1'b1, 16'h2832, 2'd0, 2'd3, 8'h00, 4'h1, 4'd9},  // R9
        {1'b1, 16'h2C35, 2'd0, 2'd3, 8'h00, 4'h1, 4'd9},  // R9
        {1'b1, 16'h0433, 2'd0, 2'd1, 8'h03, 4'h7, 4'd10}, // R10 undefined
        {1'b1, 16'hE033, 2'd0, 2'd1, 8'h03, 4'h7, 4'd10}, // R10 undefined
        {1'b0, 16'hE43F, 2'd0, 2'd1, 8'h03, 4'h7, 4'd10}, // R10 not valid
        {1'b1, 16'hE435, 2'd1, 2'd1, 8'h43, 4'h5, 4'd11}, // R11 bank 1
        {1'b0, 16'h0000, 2'd0, 2'd1, 8'h03, 4'h7, 4'd11}, // R11 bank 0 kept
        {1'b1, 16'hD035, 2'd1, 2'd0, 8'h05, 4'h5, 4'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [1:0]  bank = '0;
    logic [7:0]  dbg_mem_addr = '0;
    logic [3:0]  dbg_reg_sel = '0;
    logic        skip_req, carry;
    logic [3:0]  dbg_mem_data, dbg_reg_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nibble_exec uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_valid  (instr_valid),
        .instr        (instr),
        .bank         (bank),
        .dbg_mem_addr (dbg_mem_addr),
        .dbg_reg_sel  (dbg_reg_sel),
        .skip_req     (skip_req),
        .carry        (carry),
        .dbg_mem_data (dbg_mem_data),
        .dbg_reg_data (dbg_reg_data)
    );

    task automatic check(input int req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Observe one item through the ports (called away from the edge)
    task automatic observe(input int kind, input logic [7:0] addr, input int exp, input int req);
        case (kind)
            KREG: begin dbg_reg_sel = addr[3:0]; #1; check(req, dbg_reg_data, exp, "register"); end
            KMEM: begin dbg_mem_addr = addr;     #1; check(req, dbg_mem_data, exp, "memory"); end
            KSKP: check(req, skip_req, exp, "skip_req");
            default: check(req, carry, exp, "carry");
        endcase
    endtask

    // Present one word for one edge, then settle after the edge
    task automatic step(input logic vld, input logic [15:0] w, input logic [1:0] b);
        @(negedge clk);
        instr_valid = vld;
        instr = w;
        bank = b;
        @(posedge clk);
        #1;
        instr_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        for (int i = 0; i < 16; i++) observe(KREG, 8'(i), 0, 1);
        observe(KMEM, 8'h03, 0, 1);
        observe(KMEM, 8'hFF, 0, 1);
        check(1, carry, 0, "carry after reset");
        check(1, skip_req, 0, "skip after reset");

        for (int v = 0; v < NV; v++) begin
            step(VEC[v][36], VEC[v][35:20], VEC[v][19:18]);
            observe(int'(VEC[v][17:16]), VEC[v][15:8], int'(VEC[v][7:4]), int'(VEC[v][3:0]));
        end

        // R1: reset in the middle of activity clears skip, carry and storage
        step(1'b1, 16'hF030, 2'd0);
        check(7, skip_req, 1, "skip before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(1, skip_req, 0, "skip cleared by reset");
        check(1, carry, 0, "carry cleared by reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        observe(KMEM, 8'h03, 0, 1);
        observe(KMEM, 8'h43, 0, 1);
        observe(KREG, 8'h02, 0, 1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule